// File: doc/BRIEF.md
# Pipelined Burst SRAM Datapath

A synchronous word-wide memory core for a large chip. Address, write data and the write controls are captured on a rising clock edge. The captured operation then reaches the array on the next edge. Read data leaves through an output register, so the first word of an access is one clock behind the array access. Back-to-back reads still deliver one word per clock.

Writes merge any subset of four byte lanes into the stored word. Lanes are picked by per-lane active-low strobes, which a shared active-low byte-write enable qualifies. A separate active-low global write overrides both and writes every lane.

The output pad is modelled as a data bus plus a drive flag. The flag follows the read pipeline, so a deselect takes effect one registered cycle late. The flag is further gated without a clock by an active-low output enable. It is also gated whenever a write request is being presented. A sleep input blocks all new accesses.

Top module: `pbsram_core`

## Requirements
- R1: Lane n is data bits 8n+7:8n (lane 0 = 7:0, lane 3 = 31:24). With global write high and byte-write enable low, exactly the lanes whose strobe bit bw_n[n] is low are written. The other lanes keep their stored value.
- R2: With byte-write enable high and global write high, the strobes have no effect: the cycle is a read and the array is unchanged.
- R3: Global write low writes all four lanes, whatever the byte-write enable and strobes are.
- R4: A cycle is a read when global write is high and either byte-write enable is high or all four strobes are high. A read returns the stored word.
- R5: An operation sampled at edge k produces its read data and drive flag after edge k+1. Consecutive reads return one word per clock.
- R6: An operation sampled while sel is low neither reads nor writes, and it gives no drive after the following edge. A read sampled before the deselect still completes.
- R7: rdata_drv is low whenever oe_n is high. This gating is combinational, with no clock involved.
- R8: While a write request is presented at the inputs, rdata_drv is low regardless of oe_n.
- R9: After reset, rdata_drv is low until a read completes.
- R10: An operation sampled while sleep is high neither writes the array nor drives the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the pipeline |
| sel | input | 1 | Active-high chip select, sampled |
| sleep | input | 1 | Active-high low-power request; blocks accesses |
| addr | input | ADDR_W | Word address, sampled |
| wdata | input | 32 | Write data, sampled |
| gw_n | input | 1 | Active-low global write (all lanes) |
| bwe_n | input | 1 | Active-low byte-write enable |
| bw_n | input | 4 | Active-low per-lane write strobes |
| oe_n | input | 1 | Active-low output enable, no clock |
| rdata | output | 32 | Read data from the output register |
| rdata_drv | output | 1 | High when the data outputs would drive |

## Verification
Every operation is issued on a falling edge and captured at the next rising edge k. Its data and drive flag are due after edge k+1. The driver therefore tags each expected item with the cycle count two rising edges after issue. The monitor compares only at that count, two time units after a falling edge. By then that cycle's inputs are settled, so the combinational gating by oe_n and by a presented write is applied to the expected drive flag with the inputs of the due cycle, not those of the issuing cycle.

// File: rtl/pbsram_core.sv
module pbsram_core #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel,
  input  logic                 sleep,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [LANES*8-1:0]   wdata,
  input  logic                 gw_n,
  input  logic                 bwe_n,
  input  logic [LANES-1:0]     bw_n,
  input  logic                 oe_n,
  output logic [LANES*8-1:0]   rdata,
  output logic                 rdata_drv
);
  localparam int DW    = LANES * 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0]     mem [DEPTH];
  logic [LANES-1:0]  lane_en, le_q;
  logic              wr_req, go;
  logic              rd_q, wr_q, drv_q;
  logic [ADDR_W-1:0] a_q;
  logic [DW-1:0]     wd_q, dout_q;

  assign lane_en = {LANES{~gw_n}} | ({LANES{~bwe_n}} & ~bw_n);
  assign wr_req  = |lane_en;
  assign go      = sel & ~sleep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      wr_q  <= 1'b0;
      drv_q <= 1'b0;
    end else begin
      rd_q  <= go & ~wr_req;
      wr_q  <= go & wr_req;
      drv_q <= rd_q;
    end
    a_q  <= addr;
    wd_q <= wdata;
    le_q <= lane_en;
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++)
      if (wr_q && le_q[l]) mem[a_q][l*8 +: 8] <= wd_q[l*8 +: 8];
    if (rd_q) dout_q <= mem[a_q];
  end

  assign rdata     = dout_q;
  assign rdata_drv = drv_q & ~oe_n & ~wr_req;

  p_read_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !sleep && !wr_req) |=> ##1 drv_q);
  p_deselect_late_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && !sleep) |=> ##1 !drv_q);
  p_sleep_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!wr_q && !rd_q));
  p_write_no_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> !drv_q);
  p_one_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_q && wr_q));
  p_hold_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_q |=> $stable(dout_q));
endmodule

// File: tb/pbsram_core_tb.sv
module pbsram_core_tb_top;
  logic        clk = 0, rst_n = 0, sel = 0, sleep = 0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        gw_n = 1, bwe_n = 1, oe_n = 0;
  logic [3:0]  bw_n = 4'hF;
  logic [31:0] rdata;
  logic        rdata_drv;

  pbsram_core dut_i (.clk, .rst_n, .sel, .sleep, .addr, .wdata, .gw_n,
                     .bwe_n, .bw_n, .oe_n, .rdata, .rdata_drv);

  always #5 clk = ~clk;

  typedef struct { int due; bit drv; logic [31:0] data; string req; } item_t;
  item_t q[$];
  logic [31:0] mdl [int];
  int cyc = 0, n_cmp = 0, n_bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit wr_now();
    return !gw_n || (!bwe_n && bw_n != 4'hF);
  endfunction

  task automatic issue(input logic [9:0] a, input logic [31:0] d, input logic g,
                       input logic be, input logic [3:0] b, input logic oe,
                       input logic s, input logic slp, input string req);
    item_t it;
    logic [3:0] le;
    @(negedge clk);
    addr = a; wdata = d; gw_n = g; bwe_n = be; bw_n = b; oe_n = oe;
    sel = s; sleep = slp;
    le = {4{~g}} | ({4{~be}} & ~b);
    it.due = cyc + 2; it.req = req; it.drv = 0; it.data = 'x;
    if (s && !slp) begin
      if (le != 0) begin
        logic [31:0] w;
        w = mdl.exists(a) ? mdl[a] : 32'h0;
        for (int l = 0; l < 4; l++) if (le[l]) w[l*8 +: 8] = d[l*8 +: 8];
        mdl[a] = w;
      end else begin
        it.drv = 1; it.data = mdl[a];
      end
    end
    q.push_back(it);
  endtask

  task automatic idle(input logic oe, input string req);
    issue(10'd0, 32'h0, 1'b1, 1'b1, 4'hF, oe, 1'b0, 1'b0, req);
  endtask

  always @(negedge clk) begin
    #2;
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      bit ed;
      it = q.pop_front();
      ed = it.drv && !oe_n && !wr_now();
      n_cmp++;
      if (rdata_drv !== ed) begin
        n_bad++;
        $display("FAIL %s drive at cycle %0d: got %b expected %b", it.req, cyc, rdata_drv, ed);
      end else if (it.drv && rdata !== it.data) begin
        n_bad++;
        $display("FAIL %s data at cycle %0d: got %h expected %h", it.req, cyc, rdata, it.data);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #2; n_cmp++;
    if (rdata_drv !== 1'b0) begin
      n_bad++; $display("FAIL R9 reset drive: got %b expected 0", rdata_drv);
    end
    idle(0, "R9"); idle(0, "R9");
    // R3: global write ignores bwe/strobes
    issue(10'd5, 32'hA5A5_5A5A, 0, 1, 4'hF, 0, 1, 0, "R3");
    issue(10'd6, 32'h0102_0304, 0, 0, 4'h0, 0, 1, 0, "R3");
    issue(10'd7, 32'hDEAD_BEEF, 0, 1, 4'h5, 0, 1, 0, "R3");
    idle(0, "R3");
    issue(10'd5, 32'h0, 1, 1, 4'hF, 0, 1, 0, "R3");
    idle(0, "R4");
    // R1: lanes 0 and 2 (bw_n = 1010) only
    issue(10'd5, 32'h1122_3344, 1, 0, 4'b1010, 0, 1, 0, "R1");
    issue(10'd5, 32'h0, 1, 1, 4'hF, 0, 1, 0, "R1");
    issue(10'd6, 32'hFFEE_DDCC, 1, 0, 4'b0111, 0, 1, 0, "R1");
    issue(10'd6, 32'h0, 1, 1, 4'hF, 0, 1, 0, "R1");
    // R2: strobes ignored with bwe high -> read, array unchanged
    issue(10'd5, 32'hFFFF_FFFF, 1, 1, 4'h0, 0, 1, 0, "R2");
    issue(10'd5, 32'h0, 1, 1, 4'hF, 0, 1, 0, "R2");
    // R4: all strobes high with bwe low is a read
    issue(10'd7, 32'h1234_5678, 1, 0, 4'hF, 0, 1, 0, "R4");
    idle(0, "R4");
    // R5: burst of back-to-back reads
    issue(10'd5, 32'h0, 1, 1, 4'hF, 0, 1, 0, "R5");
    issue(10'd6, 32'h0, 1, 1, 4'hF, 0, 1, 0, "R5");
    issue(10'd7, 32'h0, 1, 1, 4'hF, 0, 1, 0, "R5");
    issue(10'd5, 32'h0, 1, 1, 4'hF, 0, 1, 0, "R5");
    // R6: read then deselect; in-flight read completes, then no drive
    issue(10'd6, 32'h0, 1, 1, 4'hF, 0, 1, 0, "R6");
    issue(10'd7, 32'h0, 1, 1, 4'hF, 0, 0, 0, "R6");
    issue(10'd7, 32'h0, 1, 1, 4'hF, 0, 0, 0, "R6");
    idle(0, "R6");
    // R7: oe_n high in the due cycle of a read
    issue(10'd5, 32'h0, 1, 1, 4'hF, 0, 1, 0, "R7");
    issue(10'd6, 32'h0, 1, 1, 4'hF, 0, 1, 0, "R7");
    idle(1, "R7");
    idle(0, "R7");
    // R8: write presented in the due cycle of a read
    issue(10'd7, 32'h0, 1, 1, 4'hF, 0, 1, 0, "R8");
    issue(10'd8, 32'hCAFE_F00D, 1, 1, 4'hF, 0, 1, 0, "R8");
    issue(10'd9, 32'h5555_AAAA, 0, 1, 4'hF, 0, 1, 0, "R8");
    issue(10'd8, 32'h0, 1, 1, 4'hF, 0, 0, 0, "R8");
    idle(0, "R8");
    // R10: sleep blocks writes and reads
    issue(10'd5, 32'h0BAD_0BAD, 0, 1, 4'hF, 0, 1, 1, "R10");
    issue(10'd5, 32'h0, 1, 1, 4'hF, 0, 1, 1, "R10");
    issue(10'd5, 32'h0, 1, 1, 4'hF, 0, 1, 0, "R10");
    issue(10'd9, 32'h0, 1, 1, 4'hF, 0, 1, 0, "R10");
    idle(0, "R10"); idle(0, "R10"); idle(0, "R10");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule